// File: doc/BRIEF.md
# Execute Breakpoint Trigger Matcher

This block decides whether an instruction fetch address hits one of a small bank of debug triggers. Each trigger has a control word and an address word. On every cycle where the program-counter strobe is high, all triggers are checked in parallel. One registered cycle later the block reports whether any trigger fired, and the index of the lowest-numbered trigger that fired.

A trigger fires only if four things hold:

- its type is one of the two execute-capable kinds;
- its execute enable is set;
- its address equals the PC exactly;
- its privilege filter accepts the hart's current mode.

The privilege filter depends on the trigger kind and on whether the hart runs virtualized. The legacy kind is silent in virtualized modes. The extended kind switches to a separate pair of virtual-mode enables. A trigger that fails its filter is only skipped, and the triggers after it are still considered.

The trigger bank is presented as flat vectors, with trigger `i` occupying bits `[i*XLEN +: XLEN]`. The register access path that fills the bank lives outside this block.

Top module: `bkpt_trig_match`

## Requirements
- R1: A synchronous active-high reset clears `hit` to 0 and `hit_idx` to 0 on the following clock edge.
- R2: `hit` and `hit_idx` reflect the inputs sampled at the previous rising edge. When `pc_vld` was low at that edge, `hit` is 0.
- R3: A trigger can fire only when control bit 2 (execute enable) is 1 and its address word equals `pc` in every bit.
- R4: The trigger kind is control bits `[XLEN-1:XLEN-4]`. Only kind 2 (legacy) and kind 6 (extended) can fire; every other kind never fires.
- R5: When `virt_on` is 0, a trigger's privilege filter passes if control bit `3+priv_lvl` is 1. Privilege encodings are user = 0, supervisor = 1 and machine = 3, so the enables are bits 3, 4 and 6. The reserved encoding 2 never passes.
- R6: A kind 2 trigger never fires while `virt_on` is 1, whatever its enables.
- R7: When `virt_on` is 1, a kind 6 trigger passes only through control bit `23+priv_lvl`: bit 23 for virtual user and bit 24 for virtual supervisor. In that state its user, supervisor and machine enables have no effect, and `priv_lvl` values 2 and 3 never pass.
- R8: A trigger that fails any condition does not stop the search: a later trigger that fully matches still produces a hit.
- R9: When several triggers match, `hit_idx` names the lowest-numbered one. When `hit` is 0, `hit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_vld | input | 1 | PC strobe: `pc` holds an executed instruction address |
| pc | input | XLEN | Executed instruction address |
| priv_lvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_on | input | 1 | Hart is in a virtualized mode |
| trig_ctrl | input | NTRIG*XLEN | Control words, trigger i at `[i*XLEN +: XLEN]` |
| trig_addr | input | NTRIG*XLEN | Address words, trigger i at `[i*XLEN +: XLEN]` |
| hit | output | 1 | Registered: some trigger fired |
| hit_idx | output | max(1,clog2(NTRIG)) | Registered: lowest firing trigger, 0 when no hit |

## Verification
The directed patterns each hold everything fixed but one condition:

- the execute bit;
- a single address bit;
- the kind field;
- one privilege enable;
- the virtualization flag.

This separates a wrong bit position from a missing qualifier.

Pairs of triggers, where a lower one fails its privilege filter and a higher one matches, tell a search that stops early apart from one that skips correctly. Sets where several triggers match expose a wrong priority direction.

Random patterns mix all kinds, modes and enable sets, with addresses that are mostly equal to the PC. Matches are therefore frequent, and the interplay of enables across modes is covered broadly.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // privilege encodings seen on priv_lvl
  localparam logic [1:0] PRV_USER  = 2'd0;
  localparam logic [1:0] PRV_SUPER = 2'd1;
  localparam logic [1:0] PRV_RSVD  = 2'd2;
  localparam logic [1:0] PRV_MACH  = 2'd3;

  // trigger kinds that can fire on execution
  localparam int unsigned KIND_W      = 4;
  localparam logic [3:0]  KIND_LEGACY = 4'd2;
  localparam logic [3:0]  KIND_EXT    = 4'd6;

  // control word bit positions
  localparam int unsigned EXEC_BIT    = 2;
  localparam int unsigned MODE_EN_LSB = 3;   // U, S, -, M enables
  localparam int unsigned VIRT_EN_LSB = 23;  // VU, VS enables

endpackage

// File: rtl/trig_qualify.sv
module trig_qualify
  import bkpt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] ctrl,
  input  logic [XLEN-1:0] addr,
  input  logic [XLEN-1:0] pc,
  input  logic [1:0]      priv_lvl,
  input  logic            virt_on,
  output logic            fire
);

  logic [KIND_W-1:0] kind;
  logic              is_legacy;
  logic              is_ext;
  logic              mode_pass;
  logic              virt_pass;
  logic              priv_pass;
  logic              addr_eq;

  assign kind      = ctrl[XLEN-1 -: KIND_W];
  assign is_legacy = (kind == KIND_LEGACY);
  assign is_ext    = (kind == KIND_EXT);
  assign addr_eq   = (addr == pc);

  // Host-mode filter: one enable per real privilege level.
  always_comb begin
    case (priv_lvl)
      PRV_USER:  mode_pass = ctrl[MODE_EN_LSB + 0];
      PRV_SUPER: mode_pass = ctrl[MODE_EN_LSB + 1];
      PRV_MACH:  mode_pass = ctrl[MODE_EN_LSB + 3];
      default:   mode_pass = 1'b0;
    endcase
  end

  // Virtualized filter: only the two guest levels exist.
  always_comb begin
    case (priv_lvl)
      PRV_USER:  virt_pass = ctrl[VIRT_EN_LSB + 0];
      PRV_SUPER: virt_pass = ctrl[VIRT_EN_LSB + 1];
      default:   virt_pass = 1'b0;
    endcase
  end

  // The legacy kind has no guest enables and therefore is silent when virtualized.
  always_comb begin
    if (virt_on) priv_pass = is_ext & virt_pass;
    else         priv_pass = (is_legacy | is_ext) & mode_pass;
  end

  assign fire = priv_pass & ctrl[EXEC_BIT] & addr_eq;

endmodule

// File: rtl/trig_prio_sel.sv
module trig_prio_sel #(
  parameter int unsigned NREQ = 4,
  parameter int unsigned IDXW = 2
) (
  input  logic [NREQ-1:0] req,
  output logic            any,
  output logic [IDXW-1:0] idx
);

  assign any = |req;

  // Walk from the top so that the lowest requester is written last.
  always_comb begin
    idx = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
  end

endmodule

// File: rtl/bkpt_trig_match.sv
module bkpt_trig_match #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NTRIG = 4,
  localparam int unsigned IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1,
  localparam int unsigned BANKW = NTRIG * XLEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pc_vld,
  input  logic [XLEN-1:0]  pc,
  input  logic [1:0]       priv_lvl,
  input  logic             virt_on,
  input  logic [BANKW-1:0] trig_ctrl,
  input  logic [BANKW-1:0] trig_addr,
  output logic             hit,
  output logic [IDXW-1:0]  hit_idx
);

  logic [NTRIG-1:0] fire_vec;
  logic             any_fire;
  logic [IDXW-1:0]  low_idx;

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    trig_qualify #(.XLEN(XLEN)) u_qual (
      .ctrl     (trig_ctrl[g*XLEN +: XLEN]),
      .addr     (trig_addr[g*XLEN +: XLEN]),
      .pc       (pc),
      .priv_lvl (priv_lvl),
      .virt_on  (virt_on),
      .fire     (fire_vec[g])
    );
  end

  trig_prio_sel #(.NREQ(NTRIG), .IDXW(IDXW)) u_sel (
    .req (fire_vec),
    .any (any_fire),
    .idx (low_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit     <= 1'b0;
      hit_idx <= '0;
    end else begin
      hit     <= pc_vld & any_fire;
      hit_idx <= (pc_vld & any_fire) ? low_idx : '0;
    end
  end

endmodule

// File: rtl/bkpt_trig_match_chk.sv
module bkpt_trig_match_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NTRIG = 4,
  parameter int unsigned IDXW  = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pc_vld,
  input logic [XLEN-1:0]       pc,
  input logic                  virt_on,
  input logic [NTRIG*XLEN-1:0] trig_ctrl,
  input logic [NTRIG*XLEN-1:0] trig_addr,
  input logic                  hit,
  input logic [IDXW-1:0]       hit_idx
);

  logic                  vld_q;
  logic                  virt_q;
  logic [XLEN-1:0]       pc_q;
  logic [NTRIG*XLEN-1:0] ctrl_q;
  logic [NTRIG*XLEN-1:0] addr_q;
  logic [XLEN-1:0]       sel_ctrl;
  logic [XLEN-1:0]       sel_addr;
  logic [3:0]            sel_kind;

  always_ff @(posedge clk) begin
    vld_q  <= pc_vld;
    virt_q <= virt_on;
    pc_q   <= pc;
    ctrl_q <= trig_ctrl;
    addr_q <= trig_addr;
  end

  always_comb begin
    sel_ctrl = '0;
    sel_addr = '0;
    for (int i = 0; i < NTRIG; i++) begin
      if (hit_idx == IDXW'(i)) begin
        sel_ctrl = ctrl_q[i*XLEN +: XLEN];
        sel_addr = addr_q[i*XLEN +: XLEN];
      end
    end
  end

  assign sel_kind = sel_ctrl[XLEN-1 -: 4];

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (!hit && hit_idx == '0)); // R1
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) hit |-> vld_q); // R2
  AST_HIT_EXEC_ADDR: assert property (@(posedge clk) disable iff (rst) hit |-> (sel_ctrl[2] && sel_addr == pc_q)); // R3
  AST_HIT_KIND_OK: assert property (@(posedge clk) disable iff (rst) hit |-> (sel_kind == 4'd2 || sel_kind == 4'd6)); // R4
  AST_LEGACY_NOT_VIRT: assert property (@(posedge clk) disable iff (rst) (hit && virt_q) |-> sel_kind == 4'd6); // R6
  AST_IDX_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst) !hit |-> hit_idx == '0); // R9
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst) hit |-> int'(hit_idx) < NTRIG); // R9

endmodule

bind bkpt_trig_match bkpt_trig_match_chk #(.XLEN(XLEN), .NTRIG(NTRIG), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pc_vld    (pc_vld),
  .pc        (pc),
  .virt_on   (virt_on),
  .trig_ctrl (trig_ctrl),
  .trig_addr (trig_addr),
  .hit       (hit),
  .hit_idx   (hit_idx)
);

// File: tb/test_bkpt_trig_match.sv
module test_bkpt_trig_match;

  localparam int unsigned XLEN  = 32;
  localparam int unsigned NT    = 4;
  localparam int unsigned IDXW  = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pc_vld = 1'b0;
  logic [XLEN-1:0]  pc = '0;
  logic [1:0]       priv_lvl = 2'd3;
  logic             virt_on = 1'b0;
  logic [NT*XLEN-1:0] trig_ctrl;
  logic [NT*XLEN-1:0] trig_addr;
  logic             hit;
  logic [IDXW-1:0]  hit_idx;

  logic [XLEN-1:0] tc [NT];
  logic [XLEN-1:0] ta [NT];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < NT; g++) begin : g_pack
    assign trig_ctrl[g*XLEN +: XLEN] = tc[g];
    assign trig_addr[g*XLEN +: XLEN] = ta[g];
  end

  bkpt_trig_match #(.XLEN(XLEN), .NTRIG(NT)) i_bkpt_trig_match (
    .clk(clk), .rst(rst), .pc_vld(pc_vld), .pc(pc), .priv_lvl(priv_lvl),
    .virt_on(virt_on), .trig_ctrl(trig_ctrl), .trig_addr(trig_addr),
    .hit(hit), .hit_idx(hit_idx)
  );

  // control word: kind, exec, U, S, M, VU, VS enables
  function automatic logic [XLEN-1:0] mkc(input logic [3:0] kind, input bit ex,
      input bit u, input bit s, input bit m, input bit vu, input bit vs);
    logic [XLEN-1:0] c = '0;
    c[XLEN-1 -: 4] = kind;
    c[2] = ex; c[3] = u; c[4] = s; c[6] = m; c[23] = vu; c[24] = vs;
    return c;
  endfunction

  function automatic bit trig_ok(input int i, input logic [XLEN-1:0] p,
      input logic [1:0] pr, input logic v);
    logic [3:0] k = tc[i][XLEN-1 -: 4];
    if (k != 4'd2 && k != 4'd6) return 0;           // R4
    if (!tc[i][2] || ta[i] != p) return 0;          // R3
    if (!v) return (pr != 2'd2) && tc[i][3 + int'(pr)];   // R5
    return (k == 4'd6) && (pr < 2'd2) && tc[i][23 + int'(pr)]; // R6 R7
  endfunction

  task automatic clr_bank();
    for (int i = 0; i < NT; i++) begin tc[i] = '0; ta[i] = '0; end
  endtask

  task automatic check(input bit eh, input int ei, input string req);
    checks++;
    if (hit !== eh || int'(hit_idx) != ei) begin
      errors++;
      $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", req, hit, hit_idx, eh, ei);
    end
  endtask

  // drive one cycle at the falling edge, check the registered result one cycle later
  task automatic step(input logic [XLEN-1:0] p, input logic [1:0] pr, input logic v,
      input logic vld, input string req);
    bit eh = 0; int ei = 0;
    pc = p; priv_lvl = pr; virt_on = v; pc_vld = vld;
    for (int i = NT - 1; i >= 0; i--) if (trig_ok(i, p, pr, v)) begin eh = 1; ei = i; end
    if (!vld) begin eh = 0; ei = 0; end
    @(negedge clk);
    check(eh, ei, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: hit=%0b idx=%0d expected run to end", hit, hit_idx);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr_bank();
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(0, 0, "R1 reset");
    rst = 1'b0;

    // R3: exec bit and exact address
    tc[0] = mkc(4'd2, 1, 1, 1, 1, 0, 0); ta[0] = 32'h8000_1000;
    step(32'h8000_1000, 2'd3, 0, 1, "R3 exact match");
    step(32'h8000_1004, 2'd3, 0, 1, "R3 address differs");
    step(32'h0000_1000, 2'd3, 0, 1, "R3 top bit differs");
    tc[0][2] = 0;
    step(32'h8000_1000, 2'd3, 0, 1, "R3 exec clear");
    // R2: no strobe
    tc[0][2] = 1;
    step(32'h8000_1000, 2'd3, 0, 0, "R2 strobe low");
    // R4: other kinds silent
    tc[0] = mkc(4'd3, 1, 1, 1, 1, 1, 1);
    step(32'h8000_1000, 2'd0, 0, 1, "R4 kind 3");
    tc[0] = mkc(4'd15, 1, 1, 1, 1, 1, 1);
    step(32'h8000_1000, 2'd1, 1, 1, "R4 kind 15");
    // R5: host-mode enables
    tc[0] = mkc(4'd6, 1, 0, 1, 0, 1, 1);
    step(32'h8000_1000, 2'd0, 0, 1, "R5 user disabled");
    step(32'h8000_1000, 2'd1, 0, 1, "R5 supervisor enabled");
    step(32'h8000_1000, 2'd3, 0, 1, "R5 machine disabled");
    tc[0] = mkc(4'd2, 1, 1, 1, 1, 0, 0); tc[0][5] = 1;
    step(32'h8000_1000, 2'd2, 0, 1, "R5 reserved level");
    // R6: legacy silent when virtualized
    tc[0] = mkc(4'd2, 1, 1, 1, 1, 1, 1);
    step(32'h8000_1000, 2'd0, 1, 1, "R6 legacy in VU");
    step(32'h8000_1000, 2'd1, 1, 1, "R6 legacy in VS");
    // R7: extended kind in guest modes
    tc[0] = mkc(4'd6, 1, 1, 1, 1, 0, 0);
    step(32'h8000_1000, 2'd0, 1, 1, "R7 host enables ignored");
    tc[0] = mkc(4'd6, 1, 0, 0, 0, 1, 0);
    step(32'h8000_1000, 2'd0, 1, 1, "R7 VU enable");
    step(32'h8000_1000, 2'd1, 1, 1, "R7 VS not enabled");
    tc[0] = mkc(4'd6, 1, 1, 1, 1, 1, 1);
    step(32'h8000_1000, 2'd3, 1, 1, "R7 machine under virt");
    // R8: lower trigger fails, higher one matches
    clr_bank();
    tc[0] = mkc(4'd2, 1, 1, 1, 1, 1, 1); ta[0] = 32'h40;
    tc[2] = mkc(4'd6, 1, 0, 0, 0, 0, 1); ta[2] = 32'h40;
    step(32'h40, 2'd1, 1, 1, "R8 skip legacy in virt");
    tc[1] = mkc(4'd6, 1, 1, 0, 0, 0, 0); ta[1] = 32'h40;
    step(32'h40, 2'd1, 1, 1, "R8 skip privilege miss");
    // R9: lowest wins
    for (int i = 0; i < NT; i++) begin tc[i] = mkc(4'd6, 1, 1, 1, 1, 1, 1); ta[i] = 32'h80; end
    step(32'h80, 2'd3, 0, 1, "R9 all match");
    tc[0][2] = 0;
    step(32'h80, 2'd3, 0, 1, "R9 lowest after skip");
    step(32'h84, 2'd3, 0, 1, "R9 no hit index zero");
    // R1: reset in mid-run
    step(32'h80, 2'd3, 0, 1, "R1 hit before reset");
    rst = 1; pc_vld = 1;
    @(negedge clk);
    check(0, 0, "R1 reset after hit");
    rst = 0;

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [XLEN-1:0] p = $urandom();
      for (int i = 0; i < NT; i++) begin
        int r = $urandom_range(0, 9);
        logic [3:0] k = (r < 4) ? 4'd2 : (r < 8) ? 4'd6 : 4'($urandom());
        tc[i] = mkc(k, ($urandom_range(0, 7) != 0), $urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
        tc[i][5] = $urandom_range(0, 1);
        ta[i] = ($urandom_range(0, 3) != 0) ? p : p ^ (32'd1 << $urandom_range(0, XLEN - 1));
      end
      step(p, 2'($urandom()), 1'($urandom()), ($urandom_range(0, 7) != 0), "R5 R7 R8 R9 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule